// File: doc/BRIEF.md
# UART Receive Filter with Framing Check and Address Recognition

This block is the receive half of an asynchronous serial port for multiprocessor links. It takes an RX line that is already synchronised to the clock, plus a tick that pulses sixteen times per bit period. It rebuilds frames of 8 or 9 data bits, checks each stop bit, and compares the received byte against a programmed slave address and mask. A frame is handed to the consumer only when it qualifies under the active filtering rules.

Received frames leave through a valid/ready port. The output holds a single frame. While `out_valid_o` is high and `out_ready_i` is low, data and ninth bit stay frozen. A frame that completes during that time is dropped, so the held frame is never overwritten. A frame can load in the same cycle that the held one drains. Address and mask registers and a sticky framing-error flag are reached through a small write/read register port.

Top module: `uart_rx_filter`

## Requirements
- R1: A frame is a low start bit, then the data bits least-significant first, then (when `nine_i`=1) one extra bit, then the stop bit. The extra bit appears on `out_bit9_o`, which is 0 for 8-bit frames.
- R2: Each bit is sampled on ticks 7, 8 and 9 of its 16-tick period, counting the tick that first saw the start bit low as tick 0. The bit value is the majority of those three samples. Samples outside that window have no effect.
- R3: A start bit whose majority value is high is a false start. It yields no frame, and the receiver then decodes the next real frame correctly.
- R4: A stop bit sampled low sets the framing-error flag, read as bit 0 of register select 2.
- R5: The framing-error flag is sticky. A later frame with a good stop bit leaves it set, and so does a write of 1 to bit 0 of select 2. Only a write of 0 to bit 0 of select 2 clears it.
- R6: With `mpe_i`=0, every completed frame is delivered, including one with a bad stop bit.
- R7: With `mpe_i`=1 and `nine_i`=1, a frame whose extra bit is 0 is discarded. A frame whose extra bit is 1 is delivered only on a direct or broadcast address match.
- R8: Direct match holds when ((rx XOR addr) AND mask) is zero. A mask bit of 0 makes that bit don't-care. The address is at select 0 and the mask at select 1.
- R9: Broadcast match holds when every bit set in (addr OR mask) is also set in the received byte.
- R10: With `mpe_i`=1 and `nine_i`=0, a frame is delivered only when its stop bit is high and its byte matches (R8/R9).
- R11: While `out_valid_o`=1 and `out_ready_i`=0, the outputs hold steady. A frame completing then is dropped, and the held data is unchanged.
- R12: After reset, `out_valid_o`, the framing-error flag, the address and the mask all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Synchronised serial input |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| nine_i | input | 1 | 1 selects frames with a ninth bit |
| mpe_i | input | 1 | Enables address filtering |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 address, 1 mask, 2 status |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data for `cfg_sel_i` |
| out_valid_o | output | 1 | Held frame available |
| out_ready_i | input | 1 | Consumer accepts the held frame |
| out_data_o | output | 8 | Received data byte |
| out_bit9_o | output | 1 | Received ninth bit |

## Verification
The bench sweeps all 256 byte values through 9-bit filtered mode under a mask with don't-care bits. A design that mixed up the mask polarity, or dropped the broadcast term, would deliver or reject the wrong bytes. Glitches are placed on individual sample ticks, both inside and outside the voting window. A receiver that votes on the wrong ticks, or trusts a single sample, then returns flipped bits. The bench also sends a bad stop followed by good frames and stray writes of 1; a flag that cleared itself would read 0 too early. Back-pressure tests catch a holding register that gets overwritten, and a short start pulse catches a receiver that locks onto noise.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} rx_state_e;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
endpackage

// File: rtl/rx_sampler.sv
// Counts oversampling ticks inside a bit and votes over the three mid samples.
module rx_sampler #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic run,
  input  logic restart,
  output logic bit_stb,
  output logic bit_val
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic [CW-1:0] cnt;
  logic          s_lo, s_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      s_lo  <= 1'b1;
      s_mid <= 1'b1;
    end else if (restart) begin
      cnt <= CW'(1);
    end else if (run && tick) begin
      cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + 1'b1;
      if (cnt == CW'(MID - 1)) s_lo  <= rx;
      if (cnt == CW'(MID))     s_mid <= rx;
    end
  end

  assign bit_stb = run & tick & (cnt == CW'(MID + 1));
  assign bit_val = (s_lo & s_mid) | (s_lo & rx) | (s_mid & rx);
endmodule

// File: rtl/rx_framer.sv
// Tracks bit position inside a frame and assembles data, ninth bit and stop.
module rx_framer import uart_rx_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          nine,
  input  logic          bit_stb,
  input  logic          bit_val,
  output logic          busy,
  output logic          restart,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          b9,
  output logic          stop_ok
);
  localparam int IW = $clog2(DW + 3);

  rx_state_e     st;
  logic [IW-1:0] idx;
  logic [DW-1:0] shf;
  logic          x9;

  assign busy    = (st == ST_BUSY);
  assign restart = (st == ST_IDLE) & tick & ~rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx     <= '0;
      shf     <= '0;
      x9      <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      b9      <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (restart) begin
        st  <= ST_BUSY;
        idx <= '0;
      end else if (busy && bit_stb) begin
        if (idx == '0) begin
          if (bit_val) st <= ST_IDLE;
          else         idx <= IW'(1);
        end else if (idx <= IW'(DW)) begin
          shf <= {bit_val, shf[DW-1:1]};
          idx <= idx + 1'b1;
        end else if (nine && idx == IW'(DW + 1)) begin
          x9  <= bit_val;
          idx <= idx + 1'b1;
        end else begin
          stop_ok <= bit_val;
          done    <= 1'b1;
          data    <= shf;
          b9      <= nine & x9;
          st      <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/addr_match.sv
// Direct (masked) and broadcast comparison of a received byte.
module addr_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rx,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] mask,
  output logic          hit
);
  logic [DW-1:0] bcast;
  logic          direct, wide;

  always_comb begin
    bcast  = addr | mask;
    direct = (((rx ^ addr) & mask) == '0);
    wide   = (((rx ^ bcast) & bcast) == '0);
    hit    = direct | wide;
  end
endmodule

// File: rtl/uart_rx_filter.sv
module uart_rx_filter import uart_rx_pkg::*; #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic          nine_i,
  input  logic          mpe_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [DW-1:0] cfg_rdata_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o,
  output logic          out_bit9_o
);
  logic          bit_stb, bit_val, busy, restart;
  logic          frm_done, frm_stop_ok, frm_b9, hit;
  logic [DW-1:0] frm_data;
  logic [DW-1:0] addr_q, mask_q, data_q;
  logic          b9_q, valid_q, ferr_q;
  logic          qualify, drain, load, clr_ferr;

  rx_sampler #(.OSR(OSR)) u_smp (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .rx(rx_i),
    .run(busy), .restart(restart), .bit_stb(bit_stb), .bit_val(bit_val)
  );

  rx_framer #(.DW(DW)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .rx(rx_i), .nine(nine_i),
    .bit_stb(bit_stb), .bit_val(bit_val), .busy(busy), .restart(restart),
    .done(frm_done), .data(frm_data), .b9(frm_b9), .stop_ok(frm_stop_ok)
  );

  addr_match #(.DW(DW)) u_match (
    .rx(frm_data), .addr(addr_q), .mask(mask_q), .hit(hit)
  );

  always_comb begin
    if (!mpe_i)      qualify = 1'b1;
    else if (nine_i) qualify = frm_b9 & hit;
    else             qualify = frm_stop_ok & hit;
  end

  assign drain    = valid_q & out_ready_i;
  assign load     = frm_done & qualify & (~valid_q | drain);
  assign clr_ferr = cfg_we_i & (cfg_sel_i == SEL_STAT) & ~cfg_wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      b9_q    <= 1'b0;
      ferr_q  <= 1'b0;
      addr_q  <= '0;
      mask_q  <= '0;
    end else begin
      if (load) begin
        valid_q <= 1'b1;
        data_q  <= frm_data;
        b9_q    <= frm_b9;
      end else if (drain) begin
        valid_q <= 1'b0;
      end
      if (frm_done && !frm_stop_ok) ferr_q <= 1'b1;
      else if (clr_ferr)            ferr_q <= 1'b0;
      if (cfg_we_i && cfg_sel_i == SEL_ADDR) addr_q <= cfg_wdata_i;
      if (cfg_we_i && cfg_sel_i == SEL_MASK) mask_q <= cfg_wdata_i;
    end
  end

  always_comb begin
    case (cfg_sel_i)
      SEL_ADDR: cfg_rdata_o = addr_q;
      SEL_MASK: cfg_rdata_o = mask_q;
      SEL_STAT: cfg_rdata_o = {{(DW-1){1'b0}}, ferr_q};
      default:  cfg_rdata_o = '0;
    endcase
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
  assign out_bit9_o  = b9_q;
endmodule

// File: rtl/uart_rx_filter_chk.sv
module uart_rx_filter_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nine,
  input logic          mpe,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic          wbit0,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_bit9,
  input logic          ferr,
  input logic          frm_done,
  input logic          frm_stop_ok,
  input logic          frm_b9,
  input logic          busy,
  input logic          bit_stb
);
  // R5
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ferr) |-> $past(cfg_we && cfg_sel == 2'd2 && !wbit0));

  // R4
  ferr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !frm_stop_ok) |=> ferr);

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_bit9)));

  // R11
  load_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frm_done));

  // R7
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && mpe && nine && !frm_b9 && !out_valid) |=> !out_valid);

  // R6
  pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !mpe && !out_valid) |=> out_valid);

  // R2
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> busy);
endmodule

bind uart_rx_filter uart_rx_filter_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nine(nine_i), .mpe(mpe_i),
  .cfg_we(cfg_we_i), .cfg_sel(cfg_sel_i), .wbit0(cfg_wdata_i[0]),
  .out_valid(out_valid_o), .out_ready(out_ready_i), .out_data(out_data_o),
  .out_bit9(out_bit9_o), .ferr(ferr_q), .frm_done(frm_done),
  .frm_stop_ok(frm_stop_ok), .frm_b9(frm_b9), .busy(busy), .bit_stb(bit_stb)
);

// File: tb/uart_rx_filter_tb.sv
module uart_rx_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1, tick = 1'b0, nine = 1'b0, mpe = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0, cfg_rdata;
  logic       out_valid, out_ready = 1'b0, out_bit9;
  logic [7:0] out_data;
  int         checks = 0, errors = 0, gap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .nine_i(nine), .mpe_i(mpe),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data), .out_bit9_o(out_bit9)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic one_tick(input logic v);
    rx = v; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop,
                            input int gbit, input logic [15:0] gmask);
    int nb = nine ? 11 : 10;
    for (int bi = 0; bi < nb; bi++) begin
      logic v;
      if (bi == 0)                v = 1'b0;
      else if (bi <= 8)           v = d[bi-1];
      else if (nine && bi == 9)   v = b9;
      else                        v = stop;
      for (int k = 0; k < 16; k++)
        one_tick((bi == gbit && gmask[k]) ? ~v : v);
    end
    for (int k = 0; k < 6; k++) one_tick(1'b1);
  endtask

  task automatic plain(input logic [7:0] d, input logic b9, input logic stop);
    send_frame(d, b9, stop, -1, 16'h0);
  endtask

  task automatic drain();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [7:0] v);
    cfg_sel = s; cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] s, output logic [7:0] v);
    cfg_sel = s;
    #1 v = cfg_rdata;
  endtask

  task automatic expect_frame(input string tag, input logic [7:0] d, input logic b9);
    check(out_valid === 1'b1, {tag, " valid"}, int'(out_valid), 1);
    check(out_data === d, {tag, " data"}, int'(out_data), int'(d));
    check(out_bit9 === b9, {tag, " bit9"}, int'(out_bit9), int'(b9));
    drain();
  endtask

  task automatic expect_none(input string tag);
    check(out_valid === 1'b0, {tag, " no frame"}, int'(out_valid), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check(out_valid === 1'b0, "R12 valid", int'(out_valid), 0);
    for (int s = 0; s < 3; s++) begin
      cfg_read(2'(s), r);
      check(r === 8'h00, "R12 register", int'(r), 0);
    end

    // R1 8-bit and 9-bit framing, R6 unfiltered delivery
    plain(8'hA5, 1'b0, 1'b1);  expect_frame("R1 8bit", 8'hA5, 1'b0);
    nine = 1'b1;
    plain(8'h96, 1'b1, 1'b1);  expect_frame("R1 9bit b9=1", 8'h96, 1'b1);
    plain(8'h69, 1'b0, 1'b1);  expect_frame("R6 9bit b9=0", 8'h69, 1'b0);
    nine = 1'b0;

    // R2 voting window
    send_frame(8'hA5, 1'b0, 1'b1, 4, 16'h0100); expect_frame("R2 single glitch", 8'hA5, 1'b0);
    send_frame(8'h00, 1'b0, 1'b1, 1, 16'h0180); expect_frame("R2 double glitch", 8'h01, 1'b0);
    send_frame(8'h00, 1'b0, 1'b1, 3, 16'h0440); expect_frame("R2 outside window", 8'h00, 1'b0);

    // R3 false start
    for (int k = 0; k < 5; k++) one_tick(1'b0);
    for (int k = 0; k < 24; k++) one_tick(1'b1);
    expect_none("R3 false start");
    plain(8'h5E, 1'b0, 1'b1);  expect_frame("R3 after false start", 8'h5E, 1'b0);

    // tick gaps must not disturb decoding (R2)
    gap = 2;
    plain(8'hC3, 1'b0, 1'b1);  expect_frame("R2 tick gaps", 8'hC3, 1'b0);
    gap = 0;

    // R4 / R5 / R6 framing error
    plain(8'h7E, 1'b0, 1'b0);  expect_frame("R6 bad stop delivered", 8'h7E, 1'b0);
    cfg_read(2'd2, r); check(r[0] === 1'b1, "R4 ferr set", int'(r), 1);
    plain(8'h11, 1'b0, 1'b1);  expect_frame("R5 good frame", 8'h11, 1'b0);
    cfg_read(2'd2, r); check(r[0] === 1'b1, "R5 ferr kept by good stop", int'(r), 1);
    cfg_write(2'd2, 8'h01);
    cfg_read(2'd2, r); check(r[0] === 1'b1, "R5 ferr kept by write 1", int'(r), 1);
    cfg_write(2'd2, 8'h00);
    cfg_read(2'd2, r); check(r[0] === 1'b0, "R5 ferr cleared", int'(r), 0);

    // R11 back-pressure
    plain(8'h3A, 1'b0, 1'b1);
    plain(8'hC5, 1'b0, 1'b1);
    expect_frame("R11 held frame kept", 8'h3A, 1'b0);
    expect_none("R11 second frame dropped");

    // R7 R8 R9 sweep: 9-bit, filtering on
    cfg_write(2'd0, 8'h5A);
    cfg_write(2'd1, 8'hF3);
    cfg_read(2'd0, r); check(r === 8'h5A, "R8 addr reg", int'(r), 'h5A);
    cfg_read(2'd1, r); check(r === 8'hF3, "R8 mask reg", int'(r), 'hF3);
    nine = 1'b1; mpe = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b = 8'(v);
      logic dir = (((b ^ 8'h5A) & 8'hF3) == 8'h00);
      logic bc  = (((b ^ 8'hFB) & 8'hFB) == 8'h00);
      plain(b, 1'b1, 1'b1);
      if (dir) expect_frame("R8 direct match", b, 1'b1);
      else if (bc) expect_frame("R9 broadcast match", b, 1'b1);
      else expect_none("R7 non-match");
    end
    plain(8'h5A, 1'b0, 1'b1); expect_none("R7 b9=0 discarded");
    plain(8'hFF, 1'b0, 1'b1); expect_none("R7 b9=0 broadcast discarded");

    // R10 8-bit filtering
    nine = 1'b0;
    cfg_write(2'd0, 8'h21);
    cfg_write(2'd1, 8'hFF);
    plain(8'h21, 1'b0, 1'b1); expect_frame("R10 match good stop", 8'h21, 1'b0);
    plain(8'h21, 1'b0, 1'b0); expect_none("R10 match bad stop");
    cfg_read(2'd2, r); check(r[0] === 1'b1, "R4 ferr in filtered mode", int'(r), 1);
    plain(8'h22, 1'b0, 1'b1); expect_none("R10 mismatch");
    plain(8'hFF, 1'b0, 1'b1); expect_frame("R10 broadcast", 8'hFF, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule